// File: doc/BRIEF.md
# Dual-Result Serial Output Shifter

This block is the output side of a sampling converter that holds two 12-bit results, one from converter A and one from converter B. Each result has its own serial data line. A host frames every transfer with an active-low chip select and a serial clock. When the chip select falls, the block captures both results and a few status levels into shift registers. It then presents a 16-bit word on each line, starting with the most significant bit. Each word is a zero bit, three status tags and the 12 data bits.

The serial clock idles high. The block runs on a fast core clock and samples chip select and serial clock on that clock. Every reaction to a pin edge therefore shows at the outputs one core-clock cycle after the edge is first sampled. The zero bit is on the line as soon as the frame opens. Each later bit moves out on a falling serial clock edge. If the host keeps chip select low for a second group of 16 clocks, each line goes on to carry the other converter's word. A line then releases after the 32nd rising serial clock edge, or earlier if chip select rises. The three-state control is brought out as an output-enable per line for the pad ring to apply.

Top module: `dual_result_serializer`

## Requirements
- R1: While chip select is high, both `oe_a` and `oe_b` are low, from the cycle after the rise is sampled onwards. Serial clock activity with chip select high leaves them low.
- R2: One cycle after a chip-select fall is sampled, both enables are high and both data lines carry 0, the leading zero of the word.
- R3: Word layout, bit 15 first: bit 15 = 0; bit 14 = range tag; bit 13 = channel tag, taken from `chan_sel` at the chip-select fall (0 = channel 1, 1 = channel 2); bit 12 = converter tag (0 on `dout_a`, 1 on `dout_b` in the first word); bits 11..0 = result, most significant bit first.
- R4: The data lines change only on falling serial clock edges. After the k-th falling edge, the line carries bit 15−k of the current word, so the last data bit is out after the 15th fall. A rising edge leaves the lines unchanged.
- R5: The range tag is the level of `range_sel` sampled at the chip-select fall of the previous frame. After reset it is 0.
- R6: After the 16th falling edge of a frame, `dout_a` carries converter B's word and `dout_b` carries converter A's word, bit 15 first. This lasts through fall 31.
- R7: Both enables go low one cycle after the 32nd rising serial clock edge. They stay low for any further clocks until chip select rises and falls again, and both data lines are then 0.
- R8: A chip-select rise at any point ends the frame and releases both lines. A frame ended before 16 clocks has no effect on the next frame.
- R9: Changes on `result_a`, `result_b`, `chan_sel` and `range_sel` after the chip-select fall do not change the words shifted out in that frame.
- R10: Whenever an enable is low, the matching data line is driven 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host, idle high |
| range_sel | input | 1 | Input-span selection level, reported one frame later |
| chan_sel | input | 1 | Channel of the current conversion |
| result_a | input | 12 | Converter A result |
| result_b | input | 12 | Converter B result |
| dout_a | output | 1 | Serial data, converter A line |
| dout_b | output | 1 | Serial data, converter B line |
| oe_a | output | 1 | Drive enable for `dout_a` (low = high impedance) |
| oe_b | output | 1 | Drive enable for `dout_b` (low = high impedance) |

## Verification
A walking one runs through converter A's result while its complement runs through B's. This makes any swapped, skipped or repeated bit position show up, and it tells lane A's data apart from lane B's. The range and channel tags cycle through all four combinations, and the range tag is compared against the level used one frame earlier. That tells a one-frame-late range capture apart from a live one. Frames of 16, 32 and 36 clocks separate release on chip select from release on the 32nd rising edge. A frame cut off after a few clocks, followed by a normal frame, shows that no shift state carries over. One frame flips every input after the fall, which shows that the words come from the capture and not from the live inputs.

// File: rtl/drs_pkg.sv
// Shared types for the dual-result serializer.
// Assumes: pin events come from signals sampled on the core clock.
package drs_pkg;

    // Frame progress: idle (lines released), shifting, parked after the full frame.
    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_SHIFT  = 2'd1,
        FR_PARKED = 2'd2
    } frame_state_e;

    // Single-cycle events derived from the host pins.
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_fall;
        logic sck_rise;
    } pin_events_t;

endpackage

// File: rtl/drs_pin_events.sv
// Turns the sampled chip select and serial clock into one-cycle edge events.
// Assumes: cs_n and sclk are already synchronous to clk; the serial clock idle
// level is given by SCK_IDLE so that no edge is seen out of reset.
module drs_pin_events
    import drs_pkg::*;
#(
    parameter bit SCK_IDLE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sclk,
    output pin_events_t ev
);

    logic cs_n_q;
    logic sclk_q;

    // Hold the previous pin levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            sclk_q <= SCK_IDLE;
        end else begin
            cs_n_q <= cs_n;
            sclk_q <= sclk;
        end
    end

    // Compare current and previous levels to form the events.
    always_comb begin
        ev.cs_fall  = cs_n_q & ~cs_n;
        ev.cs_rise  = ~cs_n_q & cs_n;
        ev.sck_fall = sclk_q & ~sclk;
        ev.sck_rise = ~sclk_q & sclk;
    end

endmodule

// File: rtl/drs_frame_ctrl.sv
// Frame sequencer: opens a frame on the chip-select fall, counts rising serial
// clock edges, parks the lines after the full daisy length, and closes on the
// chip-select rise. Also keeps the range level captured at the previous fall.
// Assumes: a chip-select rise always separates two falls.
module drs_frame_ctrl
    import drs_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  pin_events_t ev,
    input  logic        range_sel,
    output logic        load,
    output logic        shift,
    output logic        drive,
    output logic        range_tag
);

    localparam int FRAME_RISES = 2 * WORD_W;
    localparam int CNT_W       = $clog2(FRAME_RISES + 1);
    localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(FRAME_RISES - 1);

    frame_state_e     state;
    logic [CNT_W-1:0] rise_cnt;
    logic             range_q;

    // Advance the frame state and rising-edge count; capture range at the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FR_IDLE;
            rise_cnt <= '0;
            range_q  <= 1'b0;
        end else if (ev.cs_rise) begin
            state    <= FR_IDLE;
            rise_cnt <= '0;
        end else if (ev.cs_fall) begin
            state    <= FR_SHIFT;
            rise_cnt <= '0;
            range_q  <= range_sel;
        end else if (state == FR_SHIFT && ev.sck_rise) begin
            if (rise_cnt == LAST_RISE) begin
                state    <= FR_PARKED;
                rise_cnt <= '0;
            end else begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // Derive the lane controls from the state and the current events.
    always_comb begin
        load      = ev.cs_fall;
        shift     = (state == FR_SHIFT) & ev.sck_fall & ~ev.cs_rise;
        drive     = (state == FR_SHIFT);
        range_tag = range_q;
    end

endmodule

// File: rtl/drs_lane.sv
// One output lane: loads its own word followed by the peer converter's word
// and shifts the pair out most significant bit first.
// Assumes: load and shift are never high in the same cycle.
module drs_lane #(
    parameter int DATA_W  = 12,
    parameter bit LANE_ID = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              range_tag,
    input  logic              chan_tag,
    input  logic [DATA_W-1:0] own_data,
    input  logic [DATA_W-1:0] peer_data,
    output logic              serial_bit
);

    localparam int WORD_W = DATA_W + 4;
    localparam int PAIR_W = 2 * WORD_W;

    logic [WORD_W-1:0] own_word;
    logic [WORD_W-1:0] peer_word;
    logic [PAIR_W-1:0] pair_q;

    // Assemble both words: zero, range, channel, converter tag, result.
    always_comb begin
        own_word  = {1'b0, range_tag, chan_tag, LANE_ID, own_data};
        peer_word = {1'b0, range_tag, chan_tag, ~LANE_ID, peer_data};
    end

    // Capture the word pair at frame start, then shift left with zero fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else if (load) begin
            pair_q <= {own_word, peer_word};
        end else if (shift) begin
            pair_q <= {pair_q[PAIR_W-2:0], 1'b0};
        end
    end

    assign serial_bit = pair_q[PAIR_W-1];

endmodule

// File: rtl/dual_result_serializer.sv
// Top of the dual-result serializer: two lanes sharing one frame sequencer.
// Each lane drives its own converter's word first and the other converter's
// word second; enables release on the chip-select rise or after the full
// two-word frame.
// Assumes: host pins are synchronous to clk; enables drive the pad three-state.
module dual_result_serializer
    import drs_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter bit SCK_IDLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              range_sel,
    input  logic              chan_sel,
    input  logic [DATA_W-1:0] result_a,
    input  logic [DATA_W-1:0] result_b,
    output logic              dout_a,
    output logic              dout_b,
    output logic              oe_a,
    output logic              oe_b
);

    localparam int WORD_W = DATA_W + 4;
    localparam int LANES  = 2;

    pin_events_t       ev;
    logic              load;
    logic              shift;
    logic              drive;
    logic              range_tag;
    logic [DATA_W-1:0] res [LANES];
    logic [LANES-1:0]  lane_bit;

    assign res[0] = result_a;
    assign res[1] = result_b;

    drs_pin_events #(.SCK_IDLE(SCK_IDLE)) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .ev    (ev)
    );

    drs_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .range_sel (range_sel),
        .load      (load),
        .shift     (shift),
        .drive     (drive),
        .range_tag (range_tag)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        drs_lane #(.DATA_W(DATA_W), .LANE_ID(g == 1)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .shift      (shift),
            .range_tag  (range_tag),
            .chan_tag   (chan_sel),
            .own_data   (res[g]),
            .peer_data  (res[LANES-1-g]),
            .serial_bit (lane_bit[g])
        );
    end

    // Gate the line data with the enable so a released line reads 0.
    always_comb begin
        oe_a   = drive;
        oe_b   = drive;
        dout_a = drive & lane_bit[0];
        dout_b = drive & lane_bit[1];
    end

endmodule

// File: rtl/dual_result_serializer_chk.sv
// Protocol checker for the dual-result serializer, bound to the top module.
// Assumes: the same pin sampling as the design (one core cycle of latency).
module dual_result_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic dout_a,
    input logic dout_b,
    input logic oe_a,
    input logic oe_b
);

    logic cs_n_d;
    logic sclk_d;
    logic rise_seen;
    logic fall_seen;

    // Keep the previous pin levels for the checker's own edge view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_d <= 1'b1;
            sclk_d <= 1'b1;
        end else begin
            cs_n_d <= cs_n;
            sclk_d <= sclk;
        end
    end

    assign rise_seen = sclk & ~sclk_d;
    assign fall_seen = sclk_d & ~sclk;

    // R1: chip select high for two samples means both lines released.
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && cs_n_d) |-> (!oe_a && !oe_b));

    // R1: a line can only be driven if chip select was low one sample earlier.
    p_drive_needs_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        oe_a |-> $past(!cs_n));

    // R2: the first driven value of each frame is the leading zero.
    p_leading_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_a) |-> (!dout_a && !dout_b));

    // R4: without a falling serial clock edge, line A holds its bit.
    p_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a && !cs_n && !fall_seen) |=> (!oe_a || $stable(dout_a)));

    // R4: same for line B.
    p_hold_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_b && !cs_n && !fall_seen) |=> (!oe_b || $stable(dout_b)));

    // R7: a line releases only after a chip-select rise or a rising clock edge.
    p_release_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_a) |-> $past(cs_n || rise_seen));

endmodule

bind dual_result_serializer dual_result_serializer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .dout_a (dout_a),
    .dout_b (dout_b),
    .oe_a   (oe_a),
    .oe_b   (oe_b)
);

// File: tb/dual_result_serializer_tb.sv
// Bench for the dual-result serializer: drives frames of several lengths on
// the falling core-clock edge and samples the outputs there as well.
module dual_result_serializer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        range_sel = 1'b0;
    logic        chan_sel = 1'b0;
    logic [11:0] result_a = '0;
    logic [11:0] result_b = '0;
    logic        dout_a;
    logic        dout_b;
    logic        oe_a;
    logic        oe_b;

    int checks = 0;
    int errors = 0;
    logic range_prev = 1'b0;

    always #10 clk = ~clk;

    dual_result_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .range_sel (range_sel),
        .chan_sel  (chan_sel),
        .result_a  (result_a),
        .result_b  (result_b),
        .dout_a    (dout_a),
        .dout_b    (dout_b),
        .oe_a      (oe_a),
        .oe_b      (oe_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_word(input logic [11:0] d, input logic rng,
                                            input logic ch, input logic id);
        return {1'b0, rng, ch, id, d};
    endfunction

    function automatic logic pick(input int k, input logic [15:0] w1, input logic [15:0] w2);
        return (k < 16) ? w1[15-k] : w2[31-k];
    endfunction

    // One frame of nclk serial clocks; optionally disturb all inputs after the fall.
    task automatic frame(input logic [11:0] a, input logic [11:0] b, input logic rng,
                         input logic ch, input int nclk, input bit disturb);
        logic [15:0] wa;
        logic [15:0] wb;
        logic ea;
        logic eb;
        wa = mk_word(a, range_prev, ch, 1'b0);
        wb = mk_word(b, range_prev, ch, 1'b1);
        result_a = a; result_b = b; range_sel = rng; chan_sel = ch;
        cs_n = 1'b0;
        @(negedge clk);
        chk("R2 enables at frame open", {oe_a, oe_b}, 2'b11);
        chk("R2 leading zero", {dout_a, dout_b}, 2'b00);
        range_prev = rng;
        if (disturb) begin
            result_a = ~a; result_b = ~b; range_sel = ~rng; chan_sel = ~ch;
        end
        for (int k = 1; k <= nclk; k++) begin
            sclk = 1'b0;
            @(negedge clk);
            if (k < 32) begin
                ea = pick(k, wa, wb);
                eb = pick(k, wb, wa);
                chk(k < 16 ? (disturb ? "R9 line A own word" : "R3 line A own word")
                           : "R6 line A peer word", dout_a, ea);
                chk(k < 16 ? (disturb ? "R9 line B own word" : "R3 line B own word")
                           : "R6 line B peer word", dout_b, eb);
                chk("R4 enables during frame", {oe_a, oe_b}, 2'b11);
            end else if (k == 32) begin
                chk("R7 enables before last rise", {oe_a, oe_b}, 2'b11);
            end else begin
                chk("R7 parked enables", {oe_a, oe_b}, 2'b00);
            end
            sclk = 1'b1;
            @(negedge clk);
            if (k < 32) begin
                chk("R4 line A steady on rise", dout_a, pick(k, wa, wb));
                chk("R4 line B steady on rise", dout_b, pick(k, wb, wa));
            end else begin
                chk("R7 released after 32nd rise", {oe_a, oe_b}, 2'b00);
                chk("R10 released data zero", {dout_a, dout_b}, 2'b00);
            end
        end
        cs_n = 1'b1;
        @(negedge clk);
        chk(nclk < 16 ? "R8 abort releases" : "R8 close releases", {oe_a, oe_b}, 2'b00);
        chk("R10 idle data zero", {dout_a, dout_b}, 2'b00);
        result_a = a; result_b = b; range_sel = rng; chan_sel = ch;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 enables in reset", {oe_a, oe_b}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 enables after reset", {oe_a, oe_b}, 2'b00);
        chk("R10 data after reset", {dout_a, dout_b}, 2'b00);

        // Serial clock with chip select high must not enable anything.
        for (int i = 0; i < 4; i++) begin
            sclk = 1'b0;
            @(negedge clk);
            chk("R1 idle clock low", {oe_a, oe_b}, 2'b00);
            sclk = 1'b1;
            @(negedge clk);
            chk("R1 idle clock high", {oe_a, oe_b}, 2'b00);
        end

        // Walking one on A, its complement on B; R5 range history tracked in range_prev.
        for (int i = 0; i < 12; i++) begin
            frame(12'(1 << i), 12'(~(1 << i)), 1'(i), 1'(i >> 1), (i % 3 == 0) ? 16 : 32, 1'b0);
        end

        frame(12'h000, 12'hfff, 1'b1, 1'b0, 32, 1'b0);
        frame(12'hfff, 12'h000, 1'b0, 1'b1, 32, 1'b0);
        frame(12'ha5a, 12'h5a5, 1'b1, 1'b1, 32, 1'b0);

        // R8: cut a frame short, then a full one must be unaffected.
        frame(12'h3c3, 12'hc3c, 1'b0, 1'b0, 7, 1'b0);
        frame(12'h81f, 12'h7e0, 1'b1, 1'b0, 32, 1'b0);

        // R9: inputs flipped after the fall.
        frame(12'h6b2, 12'h19d, 1'b0, 1'b1, 32, 1'b1);

        // R7: clocks beyond 32 keep the lines parked.
        frame(12'h444, 12'hbbb, 1'b1, 1'b1, 36, 1'b0);
        frame(12'h0f0, 12'hf0f, 1'b0, 1'b0, 16, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule